// File: doc/BRIEF.md
# Scrolling Display Line Address Generator

This block drives the row side of a dot-matrix display scan. A row-timing source pulses a scan strobe once per row. On each strobe the block moves to the next row. For that row it presents two values: the common (row) output index to energise, and the display RAM line address to fetch. A frame is the main picture lines plus one indicator line, so 65 rows with the default parameters. When the last row is passed, the counter returns to row 0 and a one-cycle frame-start pulse is raised.

A controller writes the display start line at any time. That value sets which RAM line is shown on the top row. Rewriting it from frame to frame scrolls the picture or swaps between pages. A direction input selects whether the top line drives common output 0 or the last main common output.

Both the start line and the direction are held in a shadow and copied into the active set only at a frame boundary. Each frame is therefore drawn from a single offset, and the picture does not tear part way down. The interface is plain control: there is no data stream, so there is no valid/ready handshake and no back-pressure. The strobe and the write pulse are single-cycle qualifiers. The row outputs are valid in every cycle.

Top module: `scroll_line_gen`

## Requirements
- R1: After reset the row is 0, the active start line is 0 and the direction is normal. So com_idx = 0, ram_line = 0 and frame_start = 0.
- R2: Each cycle with scan_stb = 1 moves the row forward by exactly one, and the outputs show the new row in the next cycle. Without a strobe, com_idx and ram_line hold their values.
- R3: A strobe taken on the indicator row (row 64) returns the row to 0. frame_start is 1 for exactly the one cycle after that strobe and 0 in every other cycle.
- R4: With the active direction normal (com_rev = 0), com_idx equals the row for rows 0 to 63.
- R5: With the active direction reversed (com_rev = 1), com_idx equals 63 minus the row for rows 0 to 63. The top line is therefore on common output 63.
- R6: For rows 0 to 63, ram_line equals (active start line + row) mod 64.
- R7: On row 64, ram_line is 64 and com_idx is 64, whatever the start line and direction are.
- R8: A start_wr pulse (start_line is sampled when start_wr = 1) does not change ram_line during the current frame. The new value becomes active at the next wrap from row 64 to row 0.
- R9: A change on com_rev does not alter com_idx until the next wrap. At the wrap, the level present in the wrapping cycle becomes active.
- R10: A start_wr in the same cycle as the wrapping strobe is used for the new frame. When several writes occur in one frame, the last one is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_stb | input | 1 | Advance to the next row |
| start_wr | input | 1 | Write strobe for the start line |
| start_line | input | 6 | New display start line |
| com_rev | input | 1 | Common direction, 1 = reversed |
| frame_start | output | 1 | One-cycle pulse after the wrap to row 0 |
| com_idx | output | 7 | Common output index of the current row (64 = indicator) |
| ram_line | output | 7 | RAM line address to read for the current row |

## Verification
The row, the active start line and the direction all live in registers. com_idx and ram_line are decoded from them without further delay, so a strobe captured on one rising edge appears on the outputs straight after that edge. frame_start is registered and is high for the one cycle that follows the wrapping edge. A start_wr or a com_rev change must not appear on the outputs until the edge that performs the wrap. The directed tasks apply every input at a falling edge, let one rising edge capture it, and read the outputs at the next falling edge. The expected row, offset and direction come from a model that applies the same frame-boundary rule.

// File: rtl/scroll_line_pkg.sv
package scroll_line_pkg;
  typedef enum logic {
    COM_FWD = 1'b0,
    COM_BWD = 1'b1
  } com_dir_e;
endpackage

// File: rtl/sl_row_counter.sv
module sl_row_counter #(
  parameter int unsigned ROWS  = 65,
  parameter int unsigned IDX_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] row_o,
  output logic             last_o,
  output logic             wrap_o,
  output logic             frame_start_o
);
  localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(ROWS - 1);

  logic [IDX_W-1:0] row_q;

  assign last_o = (row_q == LAST_ROW);
  assign wrap_o = adv && last_o;
  assign row_o  = row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q         <= '0;
      frame_start_o <= 1'b0;
    end else begin
      frame_start_o <= wrap_o;
      if (wrap_o)
        row_q <= '0;
      else if (adv)
        row_q <= row_q + 1'b1;
    end
  end
endmodule

// File: rtl/sl_start_shadow.sv
module sl_start_shadow
  import scroll_line_pkg::*;
#(
  parameter int unsigned LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [LINE_W-1:0] wdata,
  input  com_dir_e          dir_in,
  input  logic              load,
  output logic [LINE_W-1:0] start_o,
  output com_dir_e          dir_o
);
  logic [LINE_W-1:0] pend_q;
  logic [LINE_W-1:0] pend_nxt;

  // a write in the wrapping cycle must reach the new frame
  assign pend_nxt = wr ? wdata : pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      start_o <= '0;
      dir_o   <= COM_FWD;
    end else begin
      pend_q <= pend_nxt;
      if (load) begin
        start_o <= pend_nxt;
        dir_o   <= dir_in;
      end
    end
  end
endmodule

// File: rtl/sl_line_map.sv
module sl_line_map
  import scroll_line_pkg::*;
#(
  parameter int unsigned LINES  = 64,
  parameter int unsigned LINE_W = $clog2(LINES),
  parameter int unsigned IDX_W  = $clog2(LINES + 1)
) (
  input  logic [IDX_W-1:0]  row,
  input  logic [LINE_W-1:0] start,
  input  com_dir_e          dir,
  output logic [IDX_W-1:0]  com_idx,
  output logic [IDX_W-1:0]  ram_line
);
  localparam logic [IDX_W-1:0]  IND_ROW = IDX_W'(LINES);
  localparam logic [LINE_W:0]   MOD_VAL = (LINE_W + 1)'(LINES);
  localparam logic [LINE_W-1:0] TOP_COM = LINE_W'(LINES - 1);

  logic              is_ind;
  logic [LINE_W-1:0] row_lo;
  logic [LINE_W:0]   sum;
  logic [LINE_W-1:0] wrapped;

  assign is_ind = (row == IND_ROW);
  assign row_lo = row[LINE_W-1:0];
  assign sum    = {1'b0, start} + {1'b0, row_lo};

  generate
    if ((LINES & (LINES - 1)) == 0) begin : g_pow2
      assign wrapped = sum[LINE_W-1:0];
    end else begin : g_cmp
      logic [LINE_W:0] diff;
      assign diff    = sum - MOD_VAL;
      assign wrapped = (sum >= MOD_VAL) ? diff[LINE_W-1:0] : sum[LINE_W-1:0];
    end
  endgenerate

  always_comb begin
    if (is_ind) begin
      com_idx  = IND_ROW;
      ram_line = IND_ROW;
    end else begin
      ram_line = IDX_W'(wrapped);
      com_idx  = (dir == COM_BWD) ? IDX_W'(TOP_COM - row_lo) : IDX_W'(row_lo);
    end
  end
endmodule

// File: rtl/scroll_line_gen.sv
module scroll_line_gen
  import scroll_line_pkg::*;
#(
  parameter int unsigned LINES  = 64,
  parameter int unsigned LINE_W = $clog2(LINES),
  parameter int unsigned IDX_W  = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_stb,
  input  logic              start_wr,
  input  logic [LINE_W-1:0] start_line,
  input  logic              com_rev,
  output logic              frame_start,
  output logic [IDX_W-1:0]  com_idx,
  output logic [IDX_W-1:0]  ram_line
);
  localparam int unsigned ROWS = LINES + 1;

  logic [IDX_W-1:0]  row;
  logic              last_row;
  logic              wrap;
  logic [LINE_W-1:0] act_start;
  com_dir_e          act_dir;

  sl_row_counter #(.ROWS(ROWS), .IDX_W(IDX_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .adv          (scan_stb),
    .row_o        (row),
    .last_o       (last_row),
    .wrap_o       (wrap),
    .frame_start_o(frame_start)
  );

  sl_start_shadow #(.LINE_W(LINE_W)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (start_wr),
    .wdata  (start_line),
    .dir_in (com_dir_e'(com_rev)),
    .load   (wrap),
    .start_o(act_start),
    .dir_o  (act_dir)
  );

  sl_line_map #(.LINES(LINES), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_map (
    .row     (row),
    .start   (act_start),
    .dir     (act_dir),
    .com_idx (com_idx),
    .ram_line(ram_line)
  );
endmodule

// File: rtl/scroll_line_gen_chk.sv
module scroll_line_gen_chk #(
  parameter int unsigned LINES  = 64,
  parameter int unsigned LINE_W = $clog2(LINES),
  parameter int unsigned IDX_W  = $clog2(LINES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_stb,
  input logic              frame_start,
  input logic [IDX_W-1:0]  com_idx,
  input logic [IDX_W-1:0]  ram_line,
  input logic [IDX_W-1:0]  row,
  input logic              last_row,
  input logic [LINE_W-1:0] act_start,
  input logic              act_dir
);
  localparam logic [IDX_W-1:0] IND = IDX_W'(LINES);

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_stb && !last_row |=> row == $past(row) + 1'b1);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_stb |=> $stable(row) && $stable(com_idx) && $stable(ram_line));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_stb && last_row |=> frame_start && row == '0);

  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  assert_top_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    row == '0 |-> ram_line == IDX_W'(act_start));

  assert_indicator_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_row |-> ram_line == IND && com_idx == IND);

  assert_no_tear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_stb && last_row) |=> $stable(act_start) && $stable(act_dir));
endmodule

bind scroll_line_gen scroll_line_gen_chk #(.LINES(LINES), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scan_stb   (scan_stb),
  .frame_start(frame_start),
  .com_idx    (com_idx),
  .ram_line   (ram_line),
  .row        (row),
  .last_row   (last_row),
  .act_start  (act_start),
  .act_dir    (act_dir)
);

// File: tb/sim_scroll_line_gen.sv
module sim_scroll_line_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_stb = 1'b0;
  logic       start_wr = 1'b0;
  logic [5:0] start_line = '0;
  logic       com_rev = 1'b0;
  logic       frame_start;
  logic [6:0] com_idx;
  logic [6:0] ram_line;

  int checks = 0;
  int errors = 0;
  int m_row = 0, m_act = 0, m_pend = 0, m_rev = 0, m_fs = 0;

  always #10 clk = ~clk;

  scroll_line_gen u0 (
    .clk(clk), .rst_n(rst_n), .scan_stb(scan_stb), .start_wr(start_wr),
    .start_line(start_line), .com_rev(com_rev), .frame_start(frame_start),
    .com_idx(com_idx), .ram_line(ram_line)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (row %0d)", tag, what, got, exp, m_row);
    end
  endtask

  task automatic check_state(input string tag);
    int ec, el;
    if (m_row == 64) begin
      ec = 64; el = 64;
    end else begin
      ec = m_rev ? 63 - m_row : m_row;
      el = (m_act + m_row) % 64;
    end
    chk(tag, "com_idx", int'(com_idx), ec);
    chk(tag, "ram_line", int'(ram_line), el);
    chk(tag, "frame_start", int'(frame_start), m_fs);
  endtask

  task automatic strobe(input bit wr, input int data);
    @(negedge clk);
    scan_stb = 1'b1; start_wr = wr; start_line = 6'(data);
    @(negedge clk);
    scan_stb = 1'b0; start_wr = 1'b0;
    if (wr) m_pend = data;
    if (m_row == 64) begin
      m_row = 0; m_act = m_pend; m_rev = int'(com_rev); m_fs = 1;
    end else begin
      m_row++; m_fs = 0;
    end
  endtask

  task automatic write_only(input int data);
    @(negedge clk);
    start_wr = 1'b1; start_line = 6'(data);
    @(negedge clk);
    start_wr = 1'b0;
    m_pend = data; m_fs = 0;
  endtask

  task automatic run_to(input int target);
    while (m_row != target) strobe(1'b0, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1");
  endtask

  task automatic t_full_frame;
    for (int i = 0; i < 64; i++) begin
      strobe(1'b0, 0);
      check_state(m_row == 64 ? "R7" : "R2 R4 R6");
    end
    strobe(1'b0, 0);
    check_state("R3");
    @(negedge clk); m_fs = 0;
    check_state("R3");
  endtask

  task automatic t_hold;
    strobe(1'b0, 0);
    strobe(1'b0, 0);
    repeat (4) @(negedge clk);
    m_fs = 0;
    check_state("R2");
  endtask

  task automatic t_scroll;
    run_to(5);
    write_only(10);
    check_state("R8");
    run_to(40);
    check_state("R8");
    run_to(64);
    check_state("R7");
    strobe(1'b0, 0);
    check_state("R8");
    chk("R8", "ram_line_top", int'(ram_line), 10);
    run_to(60);
    check_state("R6");
    chk("R6", "ram_line_wrap", int'(ram_line), 6);
  endtask

  task automatic t_reverse;
    run_to(20);
    @(negedge clk); com_rev = 1'b1; m_fs = 0;
    @(negedge clk);
    check_state("R9");
    run_to(64);
    check_state("R7");
    strobe(1'b0, 0);
    check_state("R5");
    chk("R5", "com_top", int'(com_idx), 63);
    for (int i = 0; i < 63; i++) begin
      strobe(1'b0, 0);
      check_state("R5");
    end
    strobe(1'b0, 0);
    check_state("R7");
    @(negedge clk); com_rev = 1'b0; m_fs = 0;
  endtask

  task automatic t_same_cycle;
    run_to(64);
    strobe(1'b1, 33);
    check_state("R10");
    chk("R10", "ram_line_top", int'(ram_line), 33);
    run_to(3);
    write_only(7);
    write_only(50);
    run_to(64);
    strobe(1'b0, 0);
    check_state("R10");
    chk("R10", "last_write", int'(ram_line), 50);
    strobe(1'b0, 0);
    check_state("R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_full_frame();
    t_hold();
    t_scroll();
    t_reverse();
    t_same_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule